// File: doc/BRIEF.md
# Guest Exit Decision Unit

This unit sits next to a processor core that runs guest software under a host supervisor. Each cycle it can take one guest event, which is a privileged access or a fault, along with an external-interrupt pulse and the guest's interrupt-enable level. For each of these it decides whether the hardware completes the action on its own or forces a transition back to the host.

The decision combines several independent filters:
- an exception-vector bitmap;
- an I/O-port bitmap covering the 16-bit port space;
- separate read and write bitmaps for model-specific registers;
- per-bit write masks on the control registers, with shadowed read values;
- a shadow task-priority register compared against a threshold;
- two execution-control flags: one for external interrupts, one for the guest unmasking interrupts.

The three bitmaps live in small local RAMs. Host software loads them through a word-wide write port, and the core performs no system-memory accesses for them.

An event presented before clock edge k is captured at edge k, while the bitmap RAMs are read. It is decided at edge k+1. The exit request, reason code, control-register read data, control-register commit and shadow priority are all registers. An exit request stays up until the mode controller acknowledges it.

Top module: `gexit_unit`

## Requirements
- R1: When `cfg_ext_int_exit` is 1, an `ext_irq` pulse forces an exit with reason 1 whatever the level of `guest_if`. When the flag is 0, the pulse forces no exit.
- R2: When `cfg_int_win_exit` is 1, a 0-to-1 change of `guest_if` forces an exit with reason 8. A steady level forces nothing, and with the flag at 0 a rise forces nothing. `guest_if` is taken as 0 out of reset.
- R3: A task-priority write (kind 4) loads `evt_data[TPR_W-1:0]` into `tpr_shadow`. It forces an exit with reason 4 only when the value is strictly below `cfg_tpr_threshold`. No other event changes `tpr_shadow`.
- R4: A control-register write (kind 2) that changes a bit whose mask bit is 1, compared with the real value, forces an exit with reason 3 and no commit. Otherwise it raises `cr_commit` for one cycle with the index and data, and forces no exit.
- R5: A control-register read (kind 3) raises `rd_valid` for one cycle with `(shadow & mask) | (real & ~mask)` for that register, and never forces an exit.
- R6: An exception (kind 1) forces an exit with reason 2 exactly when bit `evt_vector` mod 32 of `cfg_exc_bitmap` is 1.
- R7: An I/O access (kind 5) forces an exit with reason 5 exactly when bit p of the I/O bitmap is 1, where p is `evt_port`. Bit p is bit p%32 of word p/32, loaded with `bm_sel`=0.
- R8: A register read (kind 6) or write (kind 7) forces an exit with reason 6 or 7 exactly when bit `evt_msr` of the read bitmap (`bm_sel`=1) or the write bitmap (`bm_sel`=2) is 1, using the same word/bit layout.
- R9: When several causes hold at one decision, one reason is reported by fixed priority: external interrupt (1), exception (2), control-register write (3), priority threshold (4), I/O (5), register read (6) or write (7), interrupt window (8).
- R10: `exit_req` and `exit_reason` hold steady until a cycle with `exit_ack` high, then clear on the next edge.
- R11: While an exit is pending, events and interrupt pulses are not accepted and have no side effects on `tpr_shadow`, `exit_reason`, `rd_valid` or `cr_commit`.
- R12: After reset `exit_req`, `exit_reason`, `rd_valid`, `cr_commit` and `tpr_shadow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_int_exit | input | 1 | External interrupts force exits |
| cfg_int_win_exit | input | 1 | Guest unmasking forces an exit |
| cfg_exc_bitmap | input | 32 | Exception vectors that exit |
| cfg_cr_mask | input | NUM_CR*XLEN | Per-register host-owned bit masks |
| cfg_cr_shadow | input | NUM_CR*XLEN | Values shown to the guest for masked bits |
| cr_real | input | NUM_CR*XLEN | Current real control-register values |
| cfg_tpr_threshold | input | TPR_W | Priority exit threshold |
| bm_wr_en | input | 1 | Bitmap word write strobe |
| bm_sel | input | 2 | 0 I/O, 1 register-read, 2 register-write bitmap |
| bm_waddr | input | 11 | Bitmap word address |
| bm_wdata | input | 32 | Bitmap word data |
| ext_irq | input | 1 | External interrupt pulse |
| guest_if | input | 1 | Guest interrupt-enable level |
| evt_valid | input | 1 | Event present |
| evt_kind | input | 3 | Event kind code (see requirements) |
| evt_vector | input | 8 | Exception vector |
| evt_port | input | 16 | I/O port number |
| evt_msr | input | MSR_W | Model-specific register index |
| evt_cr | input | $clog2(NUM_CR) | Control-register index |
| evt_data | input | XLEN | Write data |
| exit_ack | input | 1 | Mode controller acknowledge |
| exit_req | output | 1 | Exit pending |
| exit_reason | output | 4 | Reason code of pending exit |
| rd_valid | output | 1 | Control-register read data valid |
| rd_data | output | XLEN | Guest-visible read value |
| cr_commit | output | 1 | Direct control-register write |
| cr_commit_idx | output | $clog2(NUM_CR) | Register written |
| cr_commit_data | output | XLEN | Value written |
| tpr_shadow | output | TPR_W | Shadow task-priority value |

## Verification
The bench probes each filter on both sides of its edge:
- An adjacent clear bitmap bit next to a set one. A core that put the port or register index into the wrong word or bit would exit on the wrong neighbour.
- A priority write equal to the threshold, where a less-or-equal compare would exit wrongly.
- A control-register write that flips only an unmasked bit, where a core that compared the full word would trap needlessly.
- A read whose result must mix shadow and real bits, where returning either whole register would show up at once.

Coincident causes check the priority order. A pending exit is held across idle cycles and then hit with a stray priority write, which catches a core that drops or overwrites its reason, or lets the ignored write touch the shadow.

// File: rtl/gexit_pkg.sv
package gexit_pkg;

  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_EXCEPTION = 3'd1,
    EV_CR_WRITE  = 3'd2,
    EV_CR_READ   = 3'd3,
    EV_TPR_WRITE = 3'd4,
    EV_IO        = 3'd5,
    EV_MSR_READ  = 3'd6,
    EV_MSR_WRITE = 3'd7
  } evt_kind_e;

  // Cause index i reports reason i+1; lower index wins.
  localparam int NUM_CAUSES  = 8;
  localparam int RSN_W       = 4;
  localparam logic [RSN_W-1:0] RSN_CR_WRITE = 4'd3;

  localparam int BM_WORD_W   = 32;

endpackage

// File: rtl/gexit_bitmap_ram.sv
module gexit_bitmap_ram #(
  parameter int BITS   = 65536,
  parameter int WORD_W = 32
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [$clog2(BITS/WORD_W)-1:0]  waddr,
  input  logic [WORD_W-1:0]               wdata,
  input  logic [$clog2(BITS)-1:0]         rbit_idx,
  output logic                            rbit
);
  localparam int DEPTH = BITS / WORD_W;
  localparam int IW    = $clog2(BITS);
  localparam int OW    = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rword;
  logic [OW-1:0]     rsel;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rword <= mem[rbit_idx[IW-1:OW]];
    rsel  <= rbit_idx[OW-1:0];
  end

  assign rbit = rword[rsel];

endmodule

// File: rtl/gexit_cr_filter.sv
module gexit_cr_filter #(
  parameter int NUM_CR = 4,
  parameter int XLEN   = 32
) (
  input  logic [$clog2(NUM_CR)-1:0] idx,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NUM_CR*XLEN-1:0]    mask_flat,
  input  logic [NUM_CR*XLEN-1:0]    shadow_flat,
  input  logic [NUM_CR*XLEN-1:0]    real_flat,
  output logic                      masked_change,
  output logic [XLEN-1:0]           read_val
);
  logic [XLEN-1:0] mask_a   [NUM_CR];
  logic [XLEN-1:0] shadow_a [NUM_CR];
  logic [XLEN-1:0] real_a   [NUM_CR];

  for (genvar g = 0; g < NUM_CR; g++) begin : g_unpack
    assign mask_a[g]   = mask_flat[g*XLEN +: XLEN];
    assign shadow_a[g] = shadow_flat[g*XLEN +: XLEN];
    assign real_a[g]   = real_flat[g*XLEN +: XLEN];
  end

  always_comb begin
    masked_change = |((wdata ^ real_a[idx]) & mask_a[idx]);
    read_val      = (shadow_a[idx] & mask_a[idx]) | (real_a[idx] & ~mask_a[idx]);
  end

endmodule

// File: rtl/gexit_prio.sv
module gexit_prio #(
  parameter int N     = 8,
  parameter int CODE_W = 4
) (
  input  logic [N-1:0]      hit,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) code = CODE_W'(i + 1);
    end
    any = |hit;
  end

endmodule

// File: rtl/gexit_unit.sv
module gexit_unit
  import gexit_pkg::*;
#(
  parameter int NUM_CR  = 4,
  parameter int XLEN    = 32,
  parameter int TPR_W   = 4,
  parameter int PORT_W  = 16,
  parameter int MSR_W   = 10,
  parameter int VEC_W   = 8,
  parameter int EXC_N   = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_ext_int_exit,
  input  logic                        cfg_int_win_exit,
  input  logic [EXC_N-1:0]            cfg_exc_bitmap,
  input  logic [NUM_CR*XLEN-1:0]      cfg_cr_mask,
  input  logic [NUM_CR*XLEN-1:0]      cfg_cr_shadow,
  input  logic [NUM_CR*XLEN-1:0]      cr_real,
  input  logic [TPR_W-1:0]            cfg_tpr_threshold,
  input  logic                        bm_wr_en,
  input  logic [1:0]                  bm_sel,
  input  logic [$clog2((1<<PORT_W)/BM_WORD_W)-1:0] bm_waddr,
  input  logic [BM_WORD_W-1:0]        bm_wdata,
  input  logic                        ext_irq,
  input  logic                        guest_if,
  input  logic                        evt_valid,
  input  logic [2:0]                  evt_kind,
  input  logic [VEC_W-1:0]            evt_vector,
  input  logic [PORT_W-1:0]           evt_port,
  input  logic [MSR_W-1:0]            evt_msr,
  input  logic [$clog2(NUM_CR)-1:0]   evt_cr,
  input  logic [XLEN-1:0]             evt_data,
  input  logic                        exit_ack,
  output logic                        exit_req,
  output logic [RSN_W-1:0]            exit_reason,
  output logic                        rd_valid,
  output logic [XLEN-1:0]             rd_data,
  output logic                        cr_commit,
  output logic [$clog2(NUM_CR)-1:0]   cr_commit_idx,
  output logic [XLEN-1:0]             cr_commit_data,
  output logic [TPR_W-1:0]            tpr_shadow
);
  localparam int IO_BITS  = 1 << PORT_W;
  localparam int MSR_BITS = 1 << MSR_W;
  localparam int IO_AW    = $clog2(IO_BITS / BM_WORD_W);
  localparam int MSR_AW   = $clog2(MSR_BITS / BM_WORD_W);
  localparam int EXC_IW   = $clog2(EXC_N);
  localparam int CR_IW    = $clog2(NUM_CR);

  // Capture stage
  logic              s1_valid, s1_ext, s1_if, s2_if;
  evt_kind_e         s1_kind;
  logic [VEC_W-1:0]  s1_vec;
  logic [CR_IW-1:0]  s1_cr;
  logic [XLEN-1:0]   s1_data;
  logic              accept;

  assign accept = !exit_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_ext   <= 1'b0;
      s1_if    <= 1'b0;
      s2_if    <= 1'b0;
      s1_kind  <= EV_NONE;
      s1_vec   <= '0;
      s1_cr    <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= evt_valid && accept;
      s1_ext   <= ext_irq && accept;
      s1_if    <= guest_if;
      s2_if    <= s1_if;
      s1_kind  <= evt_kind_e'(evt_kind);
      s1_vec   <= evt_vector;
      s1_cr    <= evt_cr;
      s1_data  <= evt_data;
    end
  end

  // Bitmap RAMs
  logic io_bit, msr_rd_bit, msr_wr_bit;

  gexit_bitmap_ram #(.BITS(IO_BITS), .WORD_W(BM_WORD_W)) u_io_bm (
    .clk(clk), .we(bm_wr_en && bm_sel == 2'd0), .waddr(bm_waddr[IO_AW-1:0]),
    .wdata(bm_wdata), .rbit_idx(evt_port), .rbit(io_bit));

  gexit_bitmap_ram #(.BITS(MSR_BITS), .WORD_W(BM_WORD_W)) u_msr_rd_bm (
    .clk(clk), .we(bm_wr_en && bm_sel == 2'd1), .waddr(bm_waddr[MSR_AW-1:0]),
    .wdata(bm_wdata), .rbit_idx(evt_msr), .rbit(msr_rd_bit));

  gexit_bitmap_ram #(.BITS(MSR_BITS), .WORD_W(BM_WORD_W)) u_msr_wr_bm (
    .clk(clk), .we(bm_wr_en && bm_sel == 2'd2), .waddr(bm_waddr[MSR_AW-1:0]),
    .wdata(bm_wdata), .rbit_idx(evt_msr), .rbit(msr_wr_bit));

  // Control-register filter
  logic            cr_masked_change;
  logic [XLEN-1:0] cr_read_val;

  gexit_cr_filter #(.NUM_CR(NUM_CR), .XLEN(XLEN)) u_cr (
    .idx(s1_cr), .wdata(s1_data), .mask_flat(cfg_cr_mask),
    .shadow_flat(cfg_cr_shadow), .real_flat(cr_real),
    .masked_change(cr_masked_change), .read_val(cr_read_val));

  // Cause vector in priority order
  logic [NUM_CAUSES-1:0] hit;
  logic                  exit_any;
  logic [RSN_W-1:0]      exit_code;
  logic                  tpr_low;

  assign tpr_low = s1_data[TPR_W-1:0] < cfg_tpr_threshold;

  always_comb begin
    hit    = '0;
    hit[0] = s1_ext && cfg_ext_int_exit;
    hit[1] = s1_valid && s1_kind == EV_EXCEPTION && cfg_exc_bitmap[s1_vec[EXC_IW-1:0]];
    hit[2] = s1_valid && s1_kind == EV_CR_WRITE && cr_masked_change;
    hit[3] = s1_valid && s1_kind == EV_TPR_WRITE && tpr_low;
    hit[4] = s1_valid && s1_kind == EV_IO && io_bit;
    hit[5] = s1_valid && s1_kind == EV_MSR_READ && msr_rd_bit;
    hit[6] = s1_valid && s1_kind == EV_MSR_WRITE && msr_wr_bit;
    hit[7] = cfg_int_win_exit && s1_if && !s2_if;
  end

  gexit_prio #(.N(NUM_CAUSES), .CODE_W(RSN_W)) u_prio (
    .hit(hit), .any(exit_any), .code(exit_code));

  // Decision stage
  always_ff @(posedge clk) begin
    if (rst) begin
      exit_req       <= 1'b0;
      exit_reason    <= '0;
      rd_valid       <= 1'b0;
      rd_data        <= '0;
      cr_commit      <= 1'b0;
      cr_commit_idx  <= '0;
      cr_commit_data <= '0;
      tpr_shadow     <= '0;
    end else begin
      rd_valid  <= 1'b0;
      cr_commit <= 1'b0;
      if (exit_req && exit_ack) begin
        exit_req    <= 1'b0;
        exit_reason <= '0;
      end
      if (!exit_req) begin
        if (exit_any) begin
          exit_req    <= 1'b1;
          exit_reason <= exit_code;
        end
        if (s1_valid && s1_kind == EV_CR_READ) begin
          rd_valid <= 1'b1;
          rd_data  <= cr_read_val;
        end
        if (s1_valid && s1_kind == EV_CR_WRITE && !cr_masked_change) begin
          cr_commit      <= 1'b1;
          cr_commit_idx  <= s1_cr;
          cr_commit_data <= s1_data;
        end
        if (s1_valid && s1_kind == EV_TPR_WRITE) tpr_shadow <= s1_data[TPR_W-1:0];
      end
    end
  end

  // Checks
  AST_EXIT_HELD: assert property (@(posedge clk) disable iff (rst)
    exit_req && !exit_ack |=> exit_req && $stable(exit_reason)); // R10
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    exit_req && exit_ack |=> !exit_req); // R10
  AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (rst)
    exit_req |-> (exit_reason != '0 && exit_reason <= RSN_W'(NUM_CAUSES))); // R9
  AST_TPR_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(s1_valid && s1_kind == EV_TPR_WRITE && !exit_req) |=> $stable(tpr_shadow)); // R3
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, cr_commit})); // R5
  AST_COMMIT_NOT_TRAP: assert property (@(posedge clk) disable iff (rst)
    cr_commit |-> !(exit_req && exit_reason == RSN_CR_WRITE && !$past(exit_req))); // R4

endmodule

// File: tb/gexit_unit_test.sv
module gexit_unit_test;
  localparam int NUM_CR = 4;
  localparam int XLEN   = 32;
  localparam int TPR_W  = 4;

  logic clk = 1'b0;
  logic rst;
  logic cfg_ext_int_exit, cfg_int_win_exit;
  logic [31:0] cfg_exc_bitmap;
  logic [NUM_CR*XLEN-1:0] cfg_cr_mask, cfg_cr_shadow, cr_real;
  logic [TPR_W-1:0] cfg_tpr_threshold;
  logic bm_wr_en;
  logic [1:0] bm_sel;
  logic [10:0] bm_waddr;
  logic [31:0] bm_wdata;
  logic ext_irq, guest_if, evt_valid, exit_ack;
  logic [2:0] evt_kind;
  logic [7:0] evt_vector;
  logic [15:0] evt_port;
  logic [9:0] evt_msr;
  logic [1:0] evt_cr;
  logic [XLEN-1:0] evt_data;
  logic exit_req, rd_valid, cr_commit;
  logic [3:0] exit_reason;
  logic [XLEN-1:0] rd_data, cr_commit_data;
  logic [1:0] cr_commit_idx;
  logic [TPR_W-1:0] tpr_shadow;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gexit_unit uut (
    .clk(clk), .rst(rst), .cfg_ext_int_exit(cfg_ext_int_exit),
    .cfg_int_win_exit(cfg_int_win_exit), .cfg_exc_bitmap(cfg_exc_bitmap),
    .cfg_cr_mask(cfg_cr_mask), .cfg_cr_shadow(cfg_cr_shadow), .cr_real(cr_real),
    .cfg_tpr_threshold(cfg_tpr_threshold), .bm_wr_en(bm_wr_en), .bm_sel(bm_sel),
    .bm_waddr(bm_waddr), .bm_wdata(bm_wdata), .ext_irq(ext_irq), .guest_if(guest_if),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_vector(evt_vector),
    .evt_port(evt_port), .evt_msr(evt_msr), .evt_cr(evt_cr), .evt_data(evt_data),
    .exit_ack(exit_ack), .exit_req(exit_req), .exit_reason(exit_reason),
    .rd_valid(rd_valid), .rd_data(rd_data), .cr_commit(cr_commit),
    .cr_commit_idx(cr_commit_idx), .cr_commit_data(cr_commit_data),
    .tpr_shadow(tpr_shadow));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bm_write(input logic [1:0] sel, input int addr, input logic [31:0] d);
    bm_wr_en = 1'b1; bm_sel = sel; bm_waddr = 11'(addr); bm_wdata = d;
    @(negedge clk);
    bm_wr_en = 1'b0;
  endtask

  // Present one event for one cycle, then wait until its decision is visible.
  task automatic issue(input logic v, input logic [2:0] kind, input logic [7:0] vec,
                       input logic [15:0] port, input logic [9:0] msr,
                       input logic [1:0] cr, input logic [31:0] d,
                       input logic irq, input logic gif);
    evt_valid = v; evt_kind = kind; evt_vector = vec; evt_port = port;
    evt_msr = msr; evt_cr = cr; evt_data = d; ext_irq = irq; guest_if = gif;
    @(negedge clk);
    evt_valid = 1'b0; ext_irq = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack_exit();
    exit_ack = 1'b1;
    @(negedge clk);
    exit_ack = 1'b0;
  endtask

  task automatic expect_exit(input string req, input logic [3:0] rsn);
    chk(req, {63'b0, exit_req}, 64'd1);
    chk(req, {60'b0, exit_reason}, {60'b0, rsn});
    ack_exit();
    chk(req, {63'b0, exit_req}, 64'd0);
  endtask

  task automatic expect_none(input string req);
    chk(req, {63'b0, exit_req}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R12 exit_req", {63'b0, exit_req}, 64'd0);
    chk("R12 reason", {60'b0, exit_reason}, 64'd0);
    chk("R12 rd_valid", {63'b0, rd_valid}, 64'd0);
    chk("R12 commit", {63'b0, cr_commit}, 64'd0);
    chk("R12 tpr", {60'b0, tpr_shadow}, 64'd0);
  endtask

  task automatic t_ext_irq();
    cfg_ext_int_exit = 1'b1;
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b1, 1'b0);
    expect_exit("R1 masked guest", 4'd1);
    cfg_ext_int_exit = 1'b0;
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b1, 1'b0);
    expect_none("R1 disabled");
    cfg_ext_int_exit = 1'b1;
  endtask

  task automatic t_exception();
    issue(1'b1, 3'd1, 8'd14, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_exit("R6 vector 14", 4'd2);
    issue(1'b1, 3'd1, 8'd3, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_none("R6 vector 3");
  endtask

  task automatic t_cr_write();
    issue(1'b1, 3'd2, 8'd0, 16'd0, 10'd0, 2'd0, 32'h1234_5778, 1'b0, 1'b0);
    expect_none("R4 unmasked write");
    // commit pulse was visible in the decision cycle, re-issue and sample it
    evt_valid = 1'b1; evt_kind = 3'd2; evt_cr = 2'd0; evt_data = 32'h1234_5778;
    @(negedge clk);
    evt_valid = 1'b0;
    @(negedge clk);
    chk("R4 commit", {63'b0, cr_commit}, 64'd1);
    chk("R4 commit data", {32'b0, cr_commit_data}, {32'b0, 32'h1234_5778});
    chk("R4 commit idx", {62'b0, cr_commit_idx}, 64'd0);
    issue(1'b1, 3'd2, 8'd0, 16'd0, 10'd0, 2'd0, 32'h1234_5679, 1'b0, 1'b0);
    chk("R4 no commit on trap", {63'b0, cr_commit}, 64'd0);
    expect_exit("R4 masked write", 4'd3);
  endtask

  task automatic t_cr_read();
    issue(1'b1, 3'd3, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    chk("R5 rd_valid", {63'b0, rd_valid}, 64'd1);
    chk("R5 mixed value", {32'b0, rd_data}, {32'b0, 32'h1234_56A5});
    expect_none("R5 read no exit");
  endtask

  task automatic t_tpr();
    issue(1'b1, 3'd4, 8'd0, 16'd0, 10'd0, 2'd0, 32'd7, 1'b0, 1'b0);
    chk("R3 shadow 7", {60'b0, tpr_shadow}, 64'd7);
    expect_none("R3 above threshold");
    issue(1'b1, 3'd4, 8'd0, 16'd0, 10'd0, 2'd0, 32'd5, 1'b0, 1'b0);
    chk("R3 shadow 5", {60'b0, tpr_shadow}, 64'd5);
    expect_none("R3 equal threshold");
    issue(1'b1, 3'd4, 8'd0, 16'd0, 10'd0, 2'd0, 32'd2, 1'b0, 1'b0);
    chk("R3 shadow 2", {60'b0, tpr_shadow}, 64'd2);
    expect_exit("R3 below threshold", 4'd4);
  endtask

  task automatic t_io();
    issue(1'b1, 3'd5, 8'd0, 16'h03F8, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_exit("R7 port 0x3F8", 4'd5);
    issue(1'b1, 3'd5, 8'd0, 16'h03F9, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_none("R7 port 0x3F9");
  endtask

  task automatic t_msr();
    issue(1'b1, 3'd6, 8'd0, 16'd0, 10'h01A, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_exit("R8 read 0x1A", 4'd6);
    issue(1'b1, 3'd7, 8'd0, 16'd0, 10'h01A, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_none("R8 write 0x1A");
    issue(1'b1, 3'd7, 8'd0, 16'd0, 10'h02B, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_exit("R8 write 0x2B", 4'd7);
    issue(1'b1, 3'd6, 8'd0, 16'd0, 10'h02B, 2'd0, 32'd0, 1'b0, 1'b0);
    expect_none("R8 read 0x2B");
  endtask

  task automatic t_window();
    cfg_int_win_exit = 1'b1;
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b1);
    expect_exit("R2 unmask", 4'd8);
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b1);
    expect_none("R2 steady level");
    cfg_int_win_exit = 1'b0;
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b1);
    expect_none("R2 disabled rise");
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    issue(1'b1, 3'd1, 8'd14, 16'd0, 10'd0, 2'd0, 32'd0, 1'b1, 1'b0);
    expect_exit("R9 ext over exception", 4'd1);
    cfg_int_win_exit = 1'b1;
    issue(1'b1, 3'd2, 8'd0, 16'd0, 10'd0, 2'd0, 32'h1234_5679, 1'b0, 1'b1);
    expect_exit("R9 cr over window", 4'd3);
    cfg_int_win_exit = 1'b0;
    issue(1'b0, 3'd0, 8'd0, 16'd0, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    issue(1'b1, 3'd5, 8'd0, 16'h03F8, 10'd0, 2'd0, 32'd0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 held req", {63'b0, exit_req}, 64'd1);
    chk("R10 held reason", {60'b0, exit_reason}, 64'd5);
    issue(1'b1, 3'd4, 8'd0, 16'd0, 10'd0, 2'd0, 32'd1, 1'b1, 1'b0);
    chk("R11 tpr untouched", {60'b0, tpr_shadow}, 64'd2);
    chk("R11 reason kept", {60'b0, exit_reason}, 64'd5);
    @(negedge clk);
    chk("R11 tpr still", {60'b0, tpr_shadow}, 64'd2);
    expect_exit("R10 ack clears", 4'd5);
    @(negedge clk);
    expect_none("R11 no late exit");
  endtask

  initial begin
    rst = 1'b1;
    cfg_ext_int_exit = 1'b1; cfg_int_win_exit = 1'b0;
    cfg_exc_bitmap = 32'h0000_4000;
    cfg_cr_mask = '0; cfg_cr_shadow = '0; cr_real = '0;
    cfg_cr_mask[31:0] = 32'h0000_00FF;
    cfg_cr_shadow[31:0] = 32'hA5A5_A5A5;
    cr_real[31:0] = 32'h1234_5678;
    cfg_tpr_threshold = 4'd5;
    bm_wr_en = 1'b0; bm_sel = 2'd0; bm_waddr = '0; bm_wdata = '0;
    ext_irq = 1'b0; guest_if = 1'b0; evt_valid = 1'b0; exit_ack = 1'b0;
    evt_kind = 3'd0; evt_vector = '0; evt_port = '0; evt_msr = '0;
    evt_cr = '0; evt_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int w = 0; w < 2048; w++) bm_write(2'd0, w, 32'd0);
    for (int w = 0; w < 32; w++) begin
      bm_write(2'd1, w, 32'd0);
      bm_write(2'd2, w, 32'd0);
    end
    bm_write(2'd0, 16'h03F8 / 32, 32'd1 << (16'h03F8 % 32));
    bm_write(2'd1, 10'h01A / 32, 32'd1 << (10'h01A % 32));
    bm_write(2'd2, 10'h02B / 32, 32'd1 << (10'h02B % 32));
    t_ext_irq();
    t_exception();
    t_cr_write();
    t_cr_read();
    t_tpr();
    t_io();
    t_msr();
    t_window();
    t_priority();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule